// File: doc/BRIEF.md
# Line Interface Start-Up and Reset Sequencer

This block sequences the start-up of a line interface. While the supply-good input is low it stays idle. Once supply-good rises it counts a settling delay, then waits until a transmit reference clock and at least one receive reference clock are actually toggling. Only then does it issue a one-cycle calibration start. For the receiver it prefers the master clock when that clock runs and falls back to the crystal oscillator otherwise. After calibration reports done, the sequencer stays in a running state with no further start-up activity. Calibration then continues in the background.

A reset request restarts the whole sequence. In hardware mode the request is the remote-loop and local-loop pins held high together long enough. In host mode it is a single register write that sets both loop bits at once. A reset pulses the register-clear and loopback-clear outputs, reruns the settling delay and calibration, and in the short-haul configuration forces loss-of-signal high until calibration completes. A watchdog raises a sticky timeout flag if calibration has not finished within a set number of cycles after receive pulses first appear.

Top module: `lif_startup_seq`

## Requirements
- R1: While `supply_ok` is low no calibration start or clear pulse is produced. `cal_start` first rises exactly SETTLE_CYC+2 clock edges after the edge that samples `supply_ok` high, counting that edge. A later supply drop returns the block to idle, and the delay restarts on the next rise.
- R2: `cal_start` is a one-cycle pulse. It is issued only when the transmit reference and at least one receive reference (master clock or crystal) are present.
- R3: `rx_ref_sel_mclk` is 1 whenever the master clock is present, whether or not the crystal runs. It is 0 when only the crystal is present.
- R4: A reference counts as present when at least MIN_EDGES rising edges arrive within a WIN_CYC-cycle window. A reference held static is absent.
- R5: With `host_mode`=0, holding `lp_remote_pin` and `lp_local_pin` both high for QUAL_CYC or more consecutive edges fires exactly one reset. An overlap of fewer edges, or one pin alone, fires none. No second reset fires until a pin drops.
- R6: With `host_mode`=1, a write (`host_wr`=1) with `host_wdata`=2'b11 (bit 0 remote loop, bit 1 local loop) fires one reset. Data 00, 01 and 10 do not. Host writes are ignored with `host_mode`=0, and the pins are ignored with `host_mode`=1.
- R7: A reset pulses `regs_clear` and `netloop_clear` for one cycle, two edges after the triggering write edge. It then reruns the settling delay and issues a new `cal_start`.
- R8: With `short_haul`=1 a reset drives `los_force` high until `cal_done`. With `short_haul`=0, `los_force` stays low.
- R9: In calibration, `cal_timeout` rises CAL_TMO_CYC+1 edges after the edge that samples the first `rx_pulse`, unless `cal_done` comes first. It stays high until a reset or a supply drop.
- R10: After `cal_done`, no further `cal_start` occurs without a reset or a supply drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| supply_ok | input | 1 | Supply-good indication |
| tx_ref_clk | input | 1 | Transmit reference clock (raw) |
| mclk_in | input | 1 | Receive master reference clock (raw) |
| xtal_in | input | 1 | Crystal oscillator reference (raw) |
| host_mode | input | 1 | 1 = host register control, 0 = hardware pins |
| short_haul | input | 1 | 1 = short-haul configuration |
| lp_remote_pin | input | 1 | Remote-loop control pin |
| lp_local_pin | input | 1 | Local-loop control pin |
| host_wr | input | 1 | Host write strobe for the loop control register |
| host_wdata | input | 2 | Write data: bit 0 remote loop, bit 1 local loop |
| rx_pulse | input | 1 | Receive pulses have been seen |
| cal_done | input | 1 | Calibration loops report lock |
| cal_start | output | 1 | One-cycle calibration start |
| rx_ref_sel_mclk | output | 1 | Receive reference select, 1 = master clock |
| regs_clear | output | 1 | One-cycle clear of all control registers |
| netloop_clear | output | 1 | One-cycle clear of network loopback |
| los_force | output | 1 | Forced loss-of-signal |
| cal_timeout | output | 1 | Sticky calibration timeout flag |

## Verification
The bench builds the block with SETTLE_CYC=20, CAL_TMO_CYC=30, QUAL_CYC=5, WIN_CYC=16 and MIN_EDGES=3. The delays are short enough to measure exactly to the cycle. This lets the bench sweep every pin-overlap length from 1 to QUAL_CYC+2, every write data value in both modes, and every reference-clock combination that matters. With these values the timeout boundary and repeated power cycles also fit in a short run.

// File: rtl/lif_seq_pkg.sv
`timescale 1ns/1ps
package lif_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_WAIT_REF,
        ST_CAL,
        ST_RUN
    } seq_state_e;

    localparam int REF_TX   = 0;
    localparam int REF_MCLK = 1;
    localparam int REF_XTAL = 2;
    localparam int N_REFS   = 3;
endpackage

// File: rtl/lif_clk_presence.sv
`timescale 1ns/1ps
module lif_clk_presence #(
    parameter int WIN_CYC   = 64,
    parameter int MIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic present
);
    localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int EW = $clog2(MIN_EDGES + 1);

    typedef struct packed {
        logic [2:0]    sync;
        logic [WW-1:0] win;
        logic [EW-1:0] edges;
        logic          present;
    } det_t;

    det_t q, d;
    logic          rise;
    logic [EW-1:0] edges_nx;

    always_comb begin
        d        = q;
        d.sync   = {q.sync[1:0], ref_in};
        rise     = q.sync[1] & ~q.sync[2];
        edges_nx = (rise && (q.edges < EW'(MIN_EDGES))) ? q.edges + 1'b1 : q.edges;
        if (q.win == WW'(WIN_CYC - 1)) begin
            d.win     = '0;
            d.present = (edges_nx >= EW'(MIN_EDGES));
            d.edges   = '0;
        end else begin
            d.win   = q.win + 1'b1;
            d.edges = edges_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign present = q.present;

    AST_PRESENT_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.win != '0) |-> $stable(q.present)); // R4
endmodule

// File: rtl/lif_reset_qual.sv
`timescale 1ns/1ps
module lif_reset_qual #(
    parameter int QUAL_CYC = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       pin_remote,
    input  logic       pin_local,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic       fire
);
    localparam int CW = $clog2(QUAL_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        logic          fire;
    } qual_t;

    qual_t q, d;
    logic  both_pins;

    always_comb begin
        d         = q;
        d.fire    = 1'b0;
        both_pins = !host_sel && pin_remote && pin_local;
        if (!both_pins) begin
            d.cnt   = '0;
            d.armed = 1'b1;
        end else if (q.armed) begin
            if (q.cnt == CW'(QUAL_CYC - 1)) begin
                d.fire  = 1'b1;
                d.armed = 1'b0;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (host_sel && wr_en && (wr_data == 2'b11)) d.fire = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, armed: 1'b1, fire: 1'b0};
        else        q <= d;
    end

    assign fire = q.fire;

    AST_HW_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !host_sel) |=> !fire); // R5
    AST_HW_NEEDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !$past(host_sel)) |-> $past(pin_remote && pin_local)); // R5
    AST_HOST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && $past(host_sel)) |-> $past(wr_en)); // R6
endmodule

// File: rtl/lif_startup_seq.sv
`timescale 1ns/1ps
module lif_startup_seq
    import lif_seq_pkg::*;
#(
    parameter int SETTLE_CYC  = 2500000,
    parameter int CAL_TMO_CYC = 5000000,
    parameter int QUAL_CYC    = 50,
    parameter int WIN_CYC     = 64,
    parameter int MIN_EDGES   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       tx_ref_clk,
    input  logic       mclk_in,
    input  logic       xtal_in,
    input  logic       host_mode,
    input  logic       short_haul,
    input  logic       lp_remote_pin,
    input  logic       lp_local_pin,
    input  logic       host_wr,
    input  logic [1:0] host_wdata,
    input  logic       rx_pulse,
    input  logic       cal_done,
    output logic       cal_start,
    output logic       rx_ref_sel_mclk,
    output logic       regs_clear,
    output logic       netloop_clear,
    output logic       los_force,
    output logic       cal_timeout
);
    localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam int TW = (CAL_TMO_CYC > 1) ? $clog2(CAL_TMO_CYC) : 1;

    logic [N_REFS-1:0] ref_raw;
    logic [N_REFS-1:0] ref_ok;
    logic              rst_fire;

    assign ref_raw[REF_TX]   = tx_ref_clk;
    assign ref_raw[REF_MCLK] = mclk_in;
    assign ref_raw[REF_XTAL] = xtal_in;

    for (genvar g = 0; g < N_REFS; g++) begin : g_ref
        lif_clk_presence #(
            .WIN_CYC   (WIN_CYC),
            .MIN_EDGES (MIN_EDGES)
        ) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_in  (ref_raw[g]),
            .present (ref_ok[g])
        );
    end

    lif_reset_qual #(
        .QUAL_CYC (QUAL_CYC)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_mode),
        .pin_remote (lp_remote_pin),
        .pin_local  (lp_local_pin),
        .wr_en      (host_wr),
        .wr_data    (host_wdata),
        .fire       (rst_fire)
    );

    typedef struct packed {
        seq_state_e    state;
        logic [SW-1:0] settle;
        logic [TW-1:0] tmr;
        logic          rx_seen;
        logic          start;
        logic          rclr;
        logic          lclr;
        logic          los;
        logic          tmo;
    } seq_t;

    seq_t q, d;
    logic refs_ready;

    always_comb begin
        d          = q;
        d.start    = 1'b0;
        d.rclr     = 1'b0;
        d.lclr     = 1'b0;
        refs_ready = ref_ok[REF_TX] && (ref_ok[REF_MCLK] || ref_ok[REF_XTAL]);
        if (!supply_ok) begin
            d.state   = ST_IDLE;
            d.settle  = '0;
            d.tmr     = '0;
            d.rx_seen = 1'b0;
            d.los     = 1'b0;
            d.tmo     = 1'b0;
        end else if (rst_fire) begin
            d.state   = ST_SETTLE;
            d.settle  = '0;
            d.tmr     = '0;
            d.rx_seen = 1'b0;
            d.rclr    = 1'b1;
            d.lclr    = 1'b1;
            d.los     = short_haul;
            d.tmo     = 1'b0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    d.state  = ST_SETTLE;
                    d.settle = '0;
                end
                ST_SETTLE: begin
                    if (q.settle == SW'(SETTLE_CYC - 1)) d.state = ST_WAIT_REF;
                    else                                 d.settle = q.settle + 1'b1;
                end
                ST_WAIT_REF: begin
                    if (refs_ready) begin
                        d.state   = ST_CAL;
                        d.start   = 1'b1;
                        d.tmr     = '0;
                        d.rx_seen = 1'b0;
                    end
                end
                ST_CAL: begin
                    if (cal_done) begin
                        d.state = ST_RUN;
                        d.los   = 1'b0;
                    end else begin
                        if (rx_pulse) d.rx_seen = 1'b1;
                        if (q.rx_seen && !q.tmo) begin
                            if (q.tmr == TW'(CAL_TMO_CYC - 1)) d.tmo = 1'b1;
                            else                               d.tmr = q.tmr + 1'b1;
                        end
                    end
                end
                default: d.state = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cal_start       = q.start;
    assign rx_ref_sel_mclk = ref_ok[REF_MCLK];
    assign regs_clear      = q.rclr;
    assign netloop_clear   = q.lclr;
    assign los_force       = q.los;
    assign cal_timeout     = q.tmo;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!cal_start && !regs_clear)); // R1
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start); // R2
    AST_START_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> $past(ref_ok[REF_TX])); // R2
    AST_CLEAR_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        regs_clear |-> $past(rst_fire)); // R7
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_timeout && supply_ok && !rst_fire) |=> cal_timeout); // R9
    AST_LOS_LONG_HAUL: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_fire && supply_ok && !short_haul) |=> !los_force); // R8
endmodule

// File: tb/lif_startup_seq_tb.sv
`timescale 1ns/1ps
module lif_startup_seq_tb;
    localparam int SETTLE = 20;
    localparam int TMO    = 30;
    localparam int QUAL   = 5;
    localparam int WIN    = 16;
    localparam int MINE   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic tx_ref_clk = 1'b0, mclk_in = 1'b0, xtal_in = 1'b0;
    logic tx_en = 1'b1, mclk_en = 1'b1, xtal_en = 1'b1;
    logic host_mode = 1'b0, short_haul = 1'b0;
    logic lp_remote_pin = 1'b0, lp_local_pin = 1'b0;
    logic host_wr = 1'b0;
    logic [1:0] host_wdata = 2'b00;
    logic rx_pulse = 1'b0, cal_done = 1'b0;
    logic cal_start, rx_ref_sel_mclk, regs_clear, netloop_clear, los_force, cal_timeout;

    int n_chk = 0, n_fail = 0;
    int n_start = 0, n_clr = 0, n_lclr = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always #6 tx_ref_clk = tx_en ? ~tx_ref_clk : 1'b0;
    always #7 mclk_in = mclk_en ? ~mclk_in : 1'b0;
    always #5 xtal_in = xtal_en ? ~xtal_in : 1'b0;

    lif_startup_seq #(
        .SETTLE_CYC (SETTLE), .CAL_TMO_CYC (TMO), .QUAL_CYC (QUAL),
        .WIN_CYC (WIN), .MIN_EDGES (MINE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok),
        .tx_ref_clk (tx_ref_clk), .mclk_in (mclk_in), .xtal_in (xtal_in),
        .host_mode (host_mode), .short_haul (short_haul),
        .lp_remote_pin (lp_remote_pin), .lp_local_pin (lp_local_pin),
        .host_wr (host_wr), .host_wdata (host_wdata),
        .rx_pulse (rx_pulse), .cal_done (cal_done),
        .cal_start (cal_start), .rx_ref_sel_mclk (rx_ref_sel_mclk),
        .regs_clear (regs_clear), .netloop_clear (netloop_clear),
        .los_force (los_force), .cal_timeout (cal_timeout)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cal_start)     n_start++;
            if (regs_clear)    n_clr++;
            if (netloop_clear) n_lclr++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_start(output int edges);
        edges = 0;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk); #1;
            edges++;
            if (cal_start) break;
        end
    endtask

    task automatic pulse_done();
        @(negedge clk) cal_done = 1'b1;
        @(negedge clk) cal_done = 1'b0;
    endtask

    task automatic power_cycle(output int edges);
        @(negedge clk) supply_ok = 1'b0;
        cycles(3 * WIN + 8);
        @(negedge clk) supply_ok = 1'b1;
        measure_start(edges);
    endtask

    initial begin
        int e, s0, c0, l0;
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        chk("R1 reset cal_start", cal_start, 0);
        chk("R1 reset regs_clear", regs_clear, 0);
        chk("R8 reset los_force", los_force, 0);
        chk("R9 reset cal_timeout", cal_timeout, 0);
        cycles(3 * WIN + 8);
        chk("R1 no start while supply low", n_start, 0);

        @(negedge clk) supply_ok = 1'b1;
        measure_start(e);
        chk("R1 settle edges to cal_start", e, SETTLE + 2);
        chk("R3 mclk+xtal selects mclk", rx_ref_sel_mclk, 1);
        @(posedge clk); #1;
        chk("R2 cal_start one cycle", cal_start, 0);

        // calibration timeout boundary
        @(negedge clk) rx_pulse = 1'b1;
        @(posedge clk);
        @(negedge clk) rx_pulse = 1'b0;
        repeat (TMO - 1) @(posedge clk);
        #1 chk("R9 no timeout before limit", cal_timeout, 0);
        @(posedge clk); #1;
        chk("R9 timeout at limit", cal_timeout, 1);
        cycles(10);
        chk("R9 timeout sticky", cal_timeout, 1);
        pulse_done();
        chk("R8 long haul los low", los_force, 0);
        s0 = n_start;
        cycles(100);
        chk("R10 no restart while running", n_start - s0, 0);

        // hardware pin overlap sweep, short haul
        short_haul = 1'b1;
        for (int len = 1; len <= QUAL + 2; len++) begin
            c0 = n_clr; l0 = n_lclr; s0 = n_start;
            @(negedge clk) begin lp_remote_pin = 1'b1; lp_local_pin = 1'b1; end
            repeat (len) @(posedge clk);
            @(negedge clk) begin lp_remote_pin = 1'b0; lp_local_pin = 1'b0; end
            cycles(4);
            chk($sformatf("R5 overlap %0d resets", len), n_clr - c0, (len >= QUAL) ? 1 : 0);
            chk("R7 loop clear with reset", n_lclr - l0, (len >= QUAL) ? 1 : 0);
            chk("R8 short haul los after reset", los_force, (len >= QUAL) ? 1 : 0);
            cycles(SETTLE + 6);
            chk("R7 recalibration after reset", n_start - s0, (len >= QUAL) ? 1 : 0);
            pulse_done();
            chk("R8 los cleared by cal_done", los_force, 0);
        end

        // one pin alone, long hold
        c0 = n_clr;
        @(negedge clk) lp_remote_pin = 1'b1;
        cycles(3 * QUAL);
        @(negedge clk) lp_remote_pin = 1'b0;
        cycles(4);
        chk("R5 single pin no reset", n_clr - c0, 0);

        // pins ignored in host mode
        host_mode = 1'b1;
        c0 = n_clr;
        @(negedge clk) begin lp_remote_pin = 1'b1; lp_local_pin = 1'b1; end
        cycles(3 * QUAL);
        @(negedge clk) begin lp_remote_pin = 1'b0; lp_local_pin = 1'b0; end
        cycles(4);
        chk("R6 pins ignored in host mode", n_clr - c0, 0);

        // host write sweep: both modes, all data values
        short_haul = 1'b0;
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 4; v++) begin
                host_mode = m[0];
                c0 = n_clr; s0 = n_start;
                @(negedge clk) begin host_wr = 1'b1; host_wdata = v[1:0]; end
                @(posedge clk);
                @(negedge clk) begin host_wr = 1'b0; host_wdata = 2'b00; end
                @(posedge clk); #1;
                chk($sformatf("R7 clear timing mode%0d data%0d", m, v), regs_clear,
                    (m == 1 && v == 3) ? 1 : 0);
                cycles(4);
                chk($sformatf("R6 host write mode%0d data%0d", m, v), n_clr - c0,
                    (m == 1 && v == 3) ? 1 : 0);
                chk("R8 long haul los stays low", los_force, 0);
                cycles(SETTLE + 6);
                chk("R7 host reset recalibrates", n_start - s0, (m == 1 && v == 3) ? 1 : 0);
                pulse_done();
            end
        end
        host_mode = 1'b0;

        // reference selection and presence
        mclk_en = 1'b0;
        power_cycle(e);
        chk("R1 delay after supply drop", e, SETTLE + 2);
        chk("R3 crystal only selects crystal", rx_ref_sel_mclk, 0);
        pulse_done();

        xtal_en = 1'b0;
        s0 = n_start;
        power_cycle(e);
        chk("R4 no rx reference no start", n_start - s0, 0);
        s0 = n_start;
        xtal_en = 1'b1;
        cycles(3 * WIN + 8);
        chk("R4 crystal detected late start", n_start - s0, 1);
        pulse_done();

        tx_en = 1'b0;
        mclk_en = 1'b1;
        s0 = n_start;
        power_cycle(e);
        chk("R2 no tx reference no start", n_start - s0, 0);
        chk("R3 mclk alone selects mclk", rx_ref_sel_mclk, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #600000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule